// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Generator

This block drives the six gate signals of a three-phase voltage-source inverter. One shared carrier counts up from zero to a programmed peak and back down, so every pulse is symmetric about the middle of the period. Each phase compares the carrier against its own signed duty value. Zero duty gives close to half on. A positive duty widens the high-side pulse and a negative duty narrows it. Large magnitudes drive the phase fully on or fully off without any stray pulse.

Each complementary pair gets a programmable dead time, so one switch never turns on while the other is still conducting. Duty values are taken from the input ports at the period start. In double-update mode they are also taken at the carrier peak. Past the dead-time logic there are three per-phase or per-output controls:
- a crossover swap of high and low, for brushless-DC commutation;
- per-output enable masks;
- per-output polarity.

An external sync pulse restarts the carrier. An asynchronous trip input forces every pin to its inactive level at once. The trip stays latched until it is cleared.

Top module: `tri_phase_pwm`

## Requirements
- R1: The carrier runs 0,1,…,P,P-1,…,1,0,1,… where P is `half_period` (P ≥ 2), so one period lasts 2P clock cycles and the period start is the cycle in which the carrier is 0.
- R2: A phase's raw high-side state is active when carrier + duty > floor(P/2), with duty taken as 16-bit two's complement; raw low side is its complement. Any duty ≥ floor(P/2)+1 gives a high side active for all 2P cycles, and any duty ≤ floor(P/2)−P gives a high side that is never active, with no pulses in either case.
- R3: Each side turns on only after its raw state has held for `dead_cycles` cycles, so its on-time per period is its raw on-time minus `dead_cycles`. A raw pulse no longer than `dead_cycles` vanishes. High and low of one phase are never active together.
- R4: With `dbl_update`=0 the duty inputs take effect only at the period start. With `dbl_update`=1 they also take effect at the carrier peak (carrier = P).
- R5: `sync_in` high at a clock edge sets the carrier to 0 counting up. A carrier value reaches the pins two cycles after the cycle in which the carrier holds it.
- R6: Bit i of `swap_mask` (bit 0 = phase A, 1 = B, 2 = C) exchanges the high and low signals of phase i after dead-time insertion.
- R7: Bit i of `en_hi` / `en_lo` set to 0 holds that output of phase i inactive.
- R8: Bit i of `pol_hi` / `pol_lo` set to 1 makes that pin active-low, so its inactive level is 1. When the bit is 0 the pin is active-high and its inactive level is 0.
- R9: `trip_in` going high forces every pin to its inactive level without waiting for a clock edge and raises `trip_active`. The forcing remains while `trip_active` is high.
- R10: The trip stays latched after `trip_in` falls. `trip_clear` releases it only when `trip_in` is low, one clock edge later.
- R11: During reset every pin sits at its inactive level and `trip_active` is 0. Reset also sets the carrier to 0 counting up and the held duties to the full-off value −32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| half_period | input | 16 | Carrier peak value P |
| dead_cycles | input | 8 | Dead time in clock cycles |
| dbl_update | input | 1 | 1: duties also taken at the carrier peak |
| duty_a | input | 16 | Signed duty, phase A |
| duty_b | input | 16 | Signed duty, phase B |
| duty_c | input | 16 | Signed duty, phase C |
| swap_mask | input | 3 | Per-phase high/low exchange |
| en_hi | input | 3 | Per-phase high-side enable |
| en_lo | input | 3 | Per-phase low-side enable |
| pol_hi | input | 3 | Per-phase high-side active-low select |
| pol_lo | input | 3 | Per-phase low-side active-low select |
| sync_in | input | 1 | Carrier restart |
| trip_in | input | 1 | Asynchronous shutdown request, active high |
| trip_clear | input | 1 | Release of the latched shutdown |
| gate_hi | output | 3 | High-side gate pins, bit i = phase i |
| gate_lo | output | 3 | Low-side gate pins, bit i = phase i |
| trip_active | output | 1 | Shutdown latched |

## Verification
Two situations are hard to reach from the ports. The first is a duty change that lands in a known half of a period, which the double-update rule depends on. The second is a trip that arrives between clock edges. For the first, the stimulus pulses `sync_in` so the carrier phase is known exactly. It then changes the duty early in the rising half and counts high-side cycles over a window that spans exactly one carrier period. For the second, `trip_in` is raised a few nanoseconds after a falling edge and the pins are checked before the next rising edge. The other duty, dead-time and masking cases are checked by counting active cycles over a whole period once the outputs have settled, so pipeline latency does not change the expected counts.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
  localparam int NPH = 3;
  typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} dir_e;
endpackage

// File: rtl/pwm3_carrier.sv
module pwm3_carrier
  import pwm3_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_in,
  input  logic [CNT_W-1:0] half_period,
  output logic [CNT_W-1:0] cnt,
  output logic             at_start,
  output logic             at_peak
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  dir_e             dir_q;

  assign cnt      = cnt_q;
  assign at_start = (cnt_q == '0);
  assign at_peak  = (dir_q == DIR_UP) && (cnt_q >= half_period);

  always_ff @(posedge clk) begin
    if (rst || sync_in) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else if (at_start) begin
      cnt_q <= ONE;
      dir_q <= DIR_UP;
    end else if (at_peak) begin
      cnt_q <= cnt_q - ONE;
      dir_q <= DIR_DOWN;
    end else if (dir_q == DIR_UP) begin
      cnt_q <= cnt_q + ONE;
    end else begin
      cnt_q <= cnt_q - ONE;
    end
  end

  // R1: rising slope advances by one per cycle
  p_climb_r1: assert property (@(posedge clk) disable iff (rst)
    (!sync_in && dir_q == DIR_UP && cnt_q != '0 && cnt_q < half_period)
      |=> (cnt_q == $past(cnt_q) + ONE));

  // R1: the trough is followed by value one
  p_trough_r1: assert property (@(posedge clk) disable iff (rst)
    (!sync_in && cnt_q == '0) |=> (cnt_q == ONE));

  // R5: restart lands at zero counting up
  p_sync_r5: assert property (@(posedge clk) disable iff (rst)
    sync_in |=> (cnt_q == '0 && dir_q == DIR_UP));
endmodule

// File: rtl/pwm3_leg.sv
module pwm3_leg #(
  parameter int CNT_W  = 16,
  parameter int DEAD_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [CNT_W-1:0]        cnt,
  input  logic [CNT_W-1:0]        half_period,
  input  logic                    dbl_update,
  input  logic                    at_start,
  input  logic                    at_peak,
  input  logic signed [CNT_W-1:0] duty_in,
  input  logic [DEAD_W-1:0]       dead_cycles,
  output logic                    hi_o,
  output logic                    lo_o
);
  localparam int EW = CNT_W + 2;
  localparam logic signed [CNT_W-1:0] DUTY_OFF = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic [DEAD_W-1:0] STAB_MAX = '1;

  logic signed [CNT_W-1:0] duty_q;
  logic                    raw_q;
  logic [DEAD_W-1:0]       stab_q;
  logic [CNT_W-1:0]        mid;
  logic signed [EW-1:0]    lvl;
  logic signed [EW-1:0]    thr;
  logic                    raw;
  logic                    take;
  logic                    settled;

  assign take = at_start || (dbl_update && at_peak);
  assign mid  = half_period >> 1;
  assign lvl  = $signed({2'b00, cnt}) + $signed({{2{duty_q[CNT_W-1]}}, duty_q});
  assign thr  = $signed({2'b00, mid});
  assign raw  = (lvl > thr);

  always_ff @(posedge clk) begin
    if (rst) begin
      duty_q <= DUTY_OFF;
      raw_q  <= 1'b0;
      stab_q <= '0;
    end else begin
      if (take) duty_q <= duty_in;
      raw_q <= raw;
      if (raw != raw_q)         stab_q <= '0;
      else if (stab_q != STAB_MAX) stab_q <= stab_q + 1'b1;
    end
  end

  assign settled = (stab_q >= dead_cycles);
  assign hi_o    = raw_q && settled;
  assign lo_o    = !raw_q && settled;

  // R4: held duty moves only at a latch point
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !take |=> (duty_q == $past(duty_q)));

  // R3: with a dead time, a side never turns on right after the other was on
  p_gap_hi_r3: assert property (@(posedge clk) disable iff (rst)
    ($rose(hi_o) && dead_cycles != '0) |-> !$past(lo_o));

  p_gap_lo_r3: assert property (@(posedge clk) disable iff (rst)
    ($rose(lo_o) && dead_cycles != '0) |-> !$past(hi_o));
endmodule

// File: rtl/pwm3_out_stage.sv
module pwm3_out_stage
  import pwm3_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic [NPH-1:0] hi_in,
  input  logic [NPH-1:0] lo_in,
  input  logic [NPH-1:0] swap_mask,
  input  logic [NPH-1:0] en_hi,
  input  logic [NPH-1:0] en_lo,
  input  logic [NPH-1:0] pol_hi,
  input  logic [NPH-1:0] pol_lo,
  input  logic           trip_in,
  input  logic           trip_clear,
  output logic [NPH-1:0] gate_hi,
  output logic [NPH-1:0] gate_lo,
  output logic           trip_active
);
  logic [NPH-1:0] sel_hi;
  logic [NPH-1:0] sel_lo;
  logic [NPH-1:0] hq;
  logic [NPH-1:0] lq;
  logic           trip_q;

  for (genvar i = 0; i < NPH; i++) begin : g_route
    assign sel_hi[i] = swap_mask[i] ? lo_in[i] : hi_in[i];
    assign sel_lo[i] = swap_mask[i] ? hi_in[i] : lo_in[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hq <= '0;
      lq <= '0;
    end else begin
      hq <= sel_hi & en_hi;
      lq <= sel_lo & en_lo;
    end
  end

  always_ff @(posedge clk or posedge trip_in) begin
    if (trip_in)         trip_q <= 1'b1;
    else if (rst)        trip_q <= 1'b0;
    else if (trip_clear) trip_q <= 1'b0;
  end

  assign gate_hi     = pol_hi ^ (hq & {NPH{~trip_q}});
  assign gate_lo     = pol_lo ^ (lq & {NPH{~trip_q}});
  assign trip_active = trip_q;

  // R3: registered pair never both active
  p_no_overlap_r3: assert property (@(posedge clk) disable iff (rst)
    ((hq & lq) == '0));

  // R9: latched trip keeps pins at their inactive levels
  p_trip_force_r9: assert property (@(posedge clk) disable iff (rst)
    trip_q |-> (gate_hi == pol_hi && gate_lo == pol_lo));

  // R10: trip cannot release while the request is still high
  p_trip_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (trip_q && trip_in) |=> trip_q);
endmodule

// File: rtl/tri_phase_pwm.sv
module tri_phase_pwm
  import pwm3_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DEAD_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [CNT_W-1:0]        half_period,
  input  logic [DEAD_W-1:0]       dead_cycles,
  input  logic                    dbl_update,
  input  logic signed [CNT_W-1:0] duty_a,
  input  logic signed [CNT_W-1:0] duty_b,
  input  logic signed [CNT_W-1:0] duty_c,
  input  logic [NPH-1:0]          swap_mask,
  input  logic [NPH-1:0]          en_hi,
  input  logic [NPH-1:0]          en_lo,
  input  logic [NPH-1:0]          pol_hi,
  input  logic [NPH-1:0]          pol_lo,
  input  logic                    sync_in,
  input  logic                    trip_in,
  input  logic                    trip_clear,
  output logic [NPH-1:0]          gate_hi,
  output logic [NPH-1:0]          gate_lo,
  output logic                    trip_active
);
  logic [CNT_W-1:0]        cnt;
  logic                    at_start;
  logic                    at_peak;
  logic signed [CNT_W-1:0] duty_v [NPH];
  logic [NPH-1:0]          leg_hi;
  logic [NPH-1:0]          leg_lo;

  assign duty_v[0] = duty_a;
  assign duty_v[1] = duty_b;
  assign duty_v[2] = duty_c;

  pwm3_carrier #(.CNT_W(CNT_W)) u_carrier (
    .clk         (clk),
    .rst         (rst),
    .sync_in     (sync_in),
    .half_period (half_period),
    .cnt         (cnt),
    .at_start    (at_start),
    .at_peak     (at_peak)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_leg
    pwm3_leg #(.CNT_W(CNT_W), .DEAD_W(DEAD_W)) u_leg (
      .clk         (clk),
      .rst         (rst),
      .cnt         (cnt),
      .half_period (half_period),
      .dbl_update  (dbl_update),
      .at_start    (at_start),
      .at_peak     (at_peak),
      .duty_in     (duty_v[p]),
      .dead_cycles (dead_cycles),
      .hi_o        (leg_hi[p]),
      .lo_o        (leg_lo[p])
    );
  end

  pwm3_out_stage u_out (
    .clk         (clk),
    .rst         (rst),
    .hi_in       (leg_hi),
    .lo_in       (leg_lo),
    .swap_mask   (swap_mask),
    .en_hi       (en_hi),
    .en_lo       (en_lo),
    .pol_hi      (pol_hi),
    .pol_lo      (pol_lo),
    .trip_in     (trip_in),
    .trip_clear  (trip_clear),
    .gate_hi     (gate_hi),
    .gate_lo     (gate_lo),
    .trip_active (trip_active)
  );
endmodule

// File: tb/tri_phase_pwm_tb_top.sv
module tri_phase_pwm_tb_top;
  logic              clk = 1'b0;
  logic              rst;
  logic [15:0]       half_period;
  logic [7:0]        dead_cycles;
  logic              dbl_update;
  logic signed [15:0] duty_a, duty_b, duty_c;
  logic [2:0]        swap_mask, en_hi, en_lo, pol_hi, pol_lo;
  logic              sync_in, trip_in, trip_clear;
  logic [2:0]        gate_hi, gate_lo;
  logic              trip_active;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  int hc [3];
  int lc [3];
  int ov [3];

  always #10 clk = ~clk;

  tri_phase_pwm dut_i (
    .clk(clk), .rst(rst), .half_period(half_period), .dead_cycles(dead_cycles),
    .dbl_update(dbl_update), .duty_a(duty_a), .duty_b(duty_b), .duty_c(duty_c),
    .swap_mask(swap_mask), .en_hi(en_hi), .en_lo(en_lo), .pol_hi(pol_hi),
    .pol_lo(pol_lo), .sync_in(sync_in), .trip_in(trip_in), .trip_clear(trip_clear),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .trip_active(trip_active)
  );

  // per: P, duty, dead, swap/enable/polarity masks, then per-period active
  // high and low counts of an unswapped, enabled phase (from R2 and R3)
  typedef struct packed {
    int         per;
    int         duty;
    int         dead;
    logic [2:0] xo;
    logic [2:0] ehm;
    logic [2:0] elm;
    logic [2:0] ph;
    logic [2:0] pl;
    int         exp_h;
    int         exp_l;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{20,      0, 0, 3'b000, 3'b111, 3'b111, 3'b000, 3'b000, 19, 21},
    '{20,      0, 3, 3'b010, 3'b111, 3'b111, 3'b000, 3'b000, 16, 18},
    '{20,      5, 2, 3'b000, 3'b101, 3'b111, 3'b000, 3'b000, 27,  9},
    '{20,     -8, 1, 3'b100, 3'b111, 3'b110, 3'b001, 3'b000,  2, 36},
    '{20,     11, 2, 3'b000, 3'b111, 3'b111, 3'b000, 3'b111, 40,  0},
    '{20,     10, 2, 3'b001, 3'b111, 3'b111, 3'b100, 3'b000, 37,  0},
    '{20,    -10, 2, 3'b000, 3'b111, 3'b111, 3'b000, 3'b000,  0, 40},
    '{20,     -9, 0, 3'b011, 3'b111, 3'b111, 3'b000, 3'b000,  1, 39},
    '{20,  32767, 4, 3'b000, 3'b111, 3'b111, 3'b111, 3'b111, 40,  0},
    '{20, -32768, 4, 3'b000, 3'b011, 3'b111, 3'b000, 3'b000,  0, 40},
    '{ 7,      0, 1, 3'b000, 3'b111, 3'b111, 3'b000, 3'b000,  6,  6},
    '{ 7,     -2, 0, 3'b110, 3'b111, 3'b111, 3'b010, 3'b000,  3, 11}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_duty(input int d);
    duty_a = 16'(d);
    duty_b = 16'(d);
    duty_c = 16'(d);
  endtask

  // leaves the bench at the sample point of cycle 0 (carrier = 0)
  task automatic do_sync();
    @(negedge clk);
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
  endtask

  // counts pin-high cycles and active-overlap cycles over n cycles
  task automatic run_window(input int n);
    for (int p = 0; p < 3; p++) begin
      hc[p] = 0; lc[p] = 0; ov[p] = 0;
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      for (int p = 0; p < 3; p++) begin
        if (gate_hi[p]) hc[p]++;
        if (gate_lo[p]) lc[p]++;
        if ((gate_hi[p] ^ pol_hi[p]) && (gate_lo[p] ^ pol_lo[p])) ov[p]++;
      end
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; half_period = 16'd20; dead_cycles = 8'd0; dbl_update = 1'b0;
    set_duty(0); swap_mask = 3'b000; en_hi = 3'b111; en_lo = 3'b111;
    pol_hi = 3'b101; pol_lo = 3'b010; sync_in = 1'b0; trip_in = 1'b0;
    trip_clear = 1'b0;
    repeat (3) @(negedge clk);
    // R11: reset state at the pins
    chk("R11 gate_hi at reset", int'(gate_hi), 5);
    chk("R11 gate_lo at reset", int'(gate_lo), 2);
    chk("R11 trip_active at reset", int'(trip_active), 0);
    pol_hi = 3'b000; pol_lo = 3'b000;
    rst = 1'b0;

    // table walk: R1 R2 R3 R6 R7 R8
    for (int v = 0; v < 12; v++) begin
      vec_t t;
      t = VECS[v];
      half_period = 16'(t.per); dead_cycles = 8'(t.dead);
      swap_mask = t.xo; en_hi = t.ehm; en_lo = t.elm;
      pol_hi = t.ph; pol_lo = t.pl;
      set_duty(t.duty);
      do_sync();
      repeat (2 * t.per + 6) @(negedge clk);
      run_window(2 * t.per);
      for (int p = 0; p < 3; p++) begin
        int eh, el, tmp;
        eh = t.exp_h; el = t.exp_l;
        if (t.xo[p]) begin tmp = eh; eh = el; el = tmp; end   // R6
        if (!t.ehm[p]) eh = 0;                               // R7
        if (!t.elm[p]) el = 0;
        if (t.ph[p]) eh = 2 * t.per - eh;                    // R8
        if (t.pl[p]) el = 2 * t.per - el;
        chk($sformatf("R2/R3/R6/R7/R8 vec%0d ph%0d high pin count", v, p), hc[p], eh);
        chk($sformatf("R2/R3/R6/R7/R8 vec%0d ph%0d low pin count", v, p), lc[p], el);
        chk($sformatf("R3 vec%0d ph%0d overlap cycles", v, p), ov[p], 0);
      end
    end

    // R5: edge timing after a restart, P=20 duty 0 no dead time
    half_period = 16'd20; dead_cycles = 8'd0; swap_mask = 3'b000;
    en_hi = 3'b111; en_lo = 3'b111; pol_hi = 3'b000; pol_lo = 3'b000;
    set_duty(0);
    do_sync();
    repeat (46) @(negedge clk);
    do_sync();
    for (int i = 0; i <= 32; i++) begin
      if (i == 12) chk("R5 high side still off at cycle 12", int'(gate_hi[0]), 0);
      if (i == 13) chk("R5 high side on at cycle 13", int'(gate_hi[0]), 1);
      if (i == 31) chk("R5 high side on at cycle 31", int'(gate_hi[0]), 1);
      if (i == 32) chk("R5 high side off at cycle 32", int'(gate_hi[0]), 0);
      @(negedge clk);
    end

    // R4: duty change in the rising half, single then double update
    for (int m = 0; m < 2; m++) begin
      int c1, c2;
      dbl_update = (m == 1);
      set_duty(0);
      do_sync();
      repeat (46) @(negedge clk);
      do_sync();
      c1 = 0; c2 = 0;
      for (int i = 0; i <= 82; i++) begin
        if (i == 5) set_duty(5);
        if (i >= 3 && i <= 42 && gate_hi[0]) c1++;
        if (i >= 43 && i <= 82 && gate_hi[0]) c2++;
        @(negedge clk);
      end
      chk($sformatf("R4 mode%0d first period high count", m), c1, (m == 1) ? 24 : 19);
      chk($sformatf("R4 mode%0d second period high count", m), c2, 29);
    end
    dbl_update = 1'b0;

    // R9 / R10: asynchronous trip and its release
    half_period = 16'd20; dead_cycles = 8'd2; set_duty(5);
    pol_hi = 3'b010; pol_lo = 3'b001;
    do_sync();
    repeat (50) @(negedge clk);
    #3 trip_in = 1'b1;
    #1;
    chk("R9 gate_hi forced before clock edge", int'(gate_hi), 2);
    chk("R9 gate_lo forced before clock edge", int'(gate_lo), 1);
    chk("R9 trip_active raised", int'(trip_active), 1);
    run_window(40);
    chk("R9 phase A high pin held inactive", hc[0], 0);
    chk("R9 phase B high pin held inactive", hc[1], 40);
    chk("R9 phase A low pin held inactive", lc[0], 40);
    trip_clear = 1'b1;
    @(negedge clk);
    trip_clear = 1'b0;
    @(negedge clk);
    chk("R10 clear ignored while trip_in high", int'(trip_active), 1);
    trip_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 trip stays latched after trip_in falls", int'(trip_active), 1);
    chk("R10 pins still inactive while latched", int'(gate_hi), 2);
    trip_clear = 1'b1;
    @(negedge clk);
    trip_clear = 1'b0;
    chk("R10 trip released by clear", int'(trip_active), 0);
    repeat (50) @(negedge clk);
    run_window(40);
    chk("R9 phase A high count after release", hc[0], 27);
    chk("R9 phase B high pin count after release", hc[1], 13);
    chk("R9 phase A low pin count after release", lc[0], 31);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule